// File: doc/BRIEF.md
# Nibble-Lane Clock and Switch Port Bridge

This block lets a 32-bit host bus talk to a real-time clock device that has sixteen 4-bit registers behind a 4-bit data port. Each of the eight word offsets the host sees covers a pair of neighbouring clock registers. On a read, the even register of the pair is copied into two nibble slots of the upper halfword and the odd register into two nibble slots of the lower halfword. Every other bit reads as zero. The host can therefore pick up either copy whichever byte lane it reads.

Two of the word offsets also carry other board signals. The lowest offset returns an 8-bit configuration switch value in its top byte. The highest offset returns the printer status byte, inverted, in its second byte. An upper-halfword write to the highest offset also loads the printer data output register.

The bridge keeps a local shadow copy of every clock register it writes. A flag records the kind of the last write, and that flag decides whether later reads are served from the shadow copy in a single cycle or from the clock device through two strobed accesses. Each access to the clock device drives a fixed-width strobe, and the host sees a one-cycle ready pulse once the transaction is complete.

Top module: `nibble_clock_bridge`

## Requirements
- R1: After reset, `bus_ready`, `clk_rd` and `clk_wr` are 0, `prn_data` is 0x00, every shadow register holds 0, and reads are served from the clock device.
- R2: A live read at word offset n makes exactly two clock accesses: the first at register address 2n, the second at 2n+1. `clk_addr` is held stable while `clk_rd` is high.
- R3: Read data carries register 2n in bits 31:28 and in bits 23:20, and register 2n+1 in bits 15:12 and in bits 7:4. Every other bit is 0.
- R4: At word offset 0, bits 31:24 of the read data are replaced by `sw_cfg[7:0]`.
- R5: At word offset 7, bits 23:16 of the read data are replaced by the bitwise inverse of `prn_status[7:0]`.
- R6: A write with `bus_be` equal to 4'b1100 (upper halfword only) stores `bus_wdata[7:4]` into register 2n. Any other byte-enable value stores `bus_wdata[23:20]` into register 2n+1. The chosen nibble goes to both the clock device and the shadow copy.
- R7: `prn_data` loads `bus_wdata[15:8]` only on a write at offset 7 with `bus_be` equal to 4'b1100. No other access changes it.
- R8: Reads come from the shadow copy if the last accepted write was at offset 0 to 5, or was an upper-halfword write at offset 6. Otherwise reads come from the clock device.
- R9: Each clock access holds `clk_rd` or `clk_wr` high for exactly 2 cycles, and the two are never high together. `bus_ready` pulses once, after the last strobe has ended. Measured from the request edge, the host sees ready after 1 cycle for a shadow read, 3 cycles for a write and 6 cycles for a live read.
- R10: A request raised while a transaction is still in progress is ignored. It changes no register, no printer output and no source selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request, sampled when the bridge is idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 3 | Word offset n |
| bus_be | input | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle completion pulse |
| clk_addr | output | 4 | Clock device register address |
| clk_wdata | output | 4 | Clock device write nibble |
| clk_rdata | input | 4 | Clock device read nibble |
| clk_rd | output | 1 | Clock device read strobe |
| clk_wr | output | 1 | Clock device write strobe |
| sw_cfg | input | 8 | Configuration switch byte |
| prn_status | input | 8 | Printer status byte |
| prn_data | output | 8 | Printer data output register |

## Verification
The assertions assume that the clock device returns its nibble combinationally while `clk_rd` is high. They also assume that `sw_cfg` and `prn_status` are steady across a read, because the overlay samples them on the completing edge. The stimulus sets the switch and status bytes once and never changes them during a transaction, and the bench's device model answers from its own memory on the same cycle. The bench raises requests only between transactions, except in the one directed case that deliberately issues a request while a live read is in flight.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
    localparam int WORD_W   = 32;
    localparam int NIB_W    = 4;
    localparam int BYTE_W   = 8;
    localparam int REG_N    = 16;
    localparam int ADDR_W   = $clog2(REG_N);
    localparam int OFF_W    = ADDR_W - 1;
    localparam int BE_W     = WORD_W / BYTE_W;

    // nibble slots inside a read word
    localparam int EVEN_HI_LSB = 28;
    localparam int EVEN_LO_LSB = 20;
    localparam int ODD_HI_LSB  = 12;
    localparam int ODD_LO_LSB  = 4;

    localparam logic [BE_W-1:0]  UPPER_ONLY_BE = 4'b1100;
    localparam logic [OFF_W-1:0] SW_OFF        = 3'd0;
    localparam logic [OFF_W-1:0] SPLIT_OFF     = 3'd6;
    localparam logic [OFF_W-1:0] PRN_OFF       = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_GAP    = 2'd2
    } state_t;

    typedef struct packed {
        logic             we;
        logic [OFF_W-1:0] off;
    } op_t;

    function automatic logic [WORD_W-1:0] place_pair(
        input logic [NIB_W-1:0] even_nib,
        input logic [NIB_W-1:0] odd_nib
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[EVEN_HI_LSB +: NIB_W] = even_nib;
        w[EVEN_LO_LSB +: NIB_W] = even_nib;
        w[ODD_HI_LSB  +: NIB_W] = odd_nib;
        w[ODD_LO_LSB  +: NIB_W] = odd_nib;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] merge_ports(
        input logic [WORD_W-1:0] w_in,
        input logic [OFF_W-1:0]  off,
        input logic [BYTE_W-1:0] sw,
        input logic [BYTE_W-1:0] pstat
    );
        logic [WORD_W-1:0] w;
        w = w_in;
        if (off == SW_OFF)  w[31:24] = sw;
        if (off == PRN_OFF) w[23:16] = ~pstat;
        return w;
    endfunction
endpackage

// File: rtl/nbb_strobe_timer.sv
module nbb_strobe_timer #(
    parameter int STROBE_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic done
);
    localparam int CNT_W = $clog2(STROBE_CYC + 1) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;

    assign active = active_q;
    assign done   = active_q && (cnt_q == CNT_W'(STROBE_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (done) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // independent width counter for the strobe check
    logic [CNT_W-1:0] width_q;
    always_ff @(posedge clk) begin
        if (rst)         width_q <= '0;
        else if (active) width_q <= width_q + 1'b1;
        else             width_q <= '0;
    end

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (!active && width_q != '0) |-> (width_q == CNT_W'(STROBE_CYC))); // R9
endmodule

// File: rtl/nbb_shadow_file.sv
module nbb_shadow_file import nbb_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [NIB_W-1:0]  wnib,
    input  logic [OFF_W-1:0]  rpair,
    output logic [NIB_W-1:0]  even_nib,
    output logic [NIB_W-1:0]  odd_nib
);
    logic [NIB_W-1:0] regs [REG_N];

    for (genvar i = 0; i < REG_N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                regs[i] <= '0;
            else if (wen && waddr == ADDR_W'(i))    regs[i] <= wnib;
        end
    end

    assign even_nib = regs[{rpair, 1'b0}];
    assign odd_nib  = regs[{rpair, 1'b1}];
endmodule

// File: rtl/nibble_clock_bridge.sv
module nibble_clock_bridge import nbb_pkg::*; #(
    parameter int STROBE_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [2:0]  bus_off,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ready,
    output logic [3:0]  clk_addr,
    output logic [3:0]  clk_wdata,
    input  logic [3:0]  clk_rdata,
    output logic        clk_rd,
    output logic        clk_wr,
    input  logic [7:0]  sw_cfg,
    input  logic [7:0]  prn_status,
    output logic [7:0]  prn_data
);
    state_t            state_q;
    op_t               op_q;
    logic              odd_phase_q;
    logic [NIB_W-1:0]  even_q;
    logic              use_shadow_q;
    logic [WORD_W-1:0] rdata_q;
    logic              ready_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NIB_W-1:0]  wnib_q;
    logic [BYTE_W-1:0] prn_q;

    logic              accept;
    logic              upper_only;
    logic [ADDR_W-1:0] wr_addr;
    logic [NIB_W-1:0]  wr_nib;
    logic              tmr_start;
    logic              tmr_active;
    logic              tmr_done;
    logic [NIB_W-1:0]  sh_even;
    logic [NIB_W-1:0]  sh_odd;
    logic              prn_load;

    assign accept     = bus_req && (state_q == ST_IDLE);
    assign upper_only = (bus_be == UPPER_ONLY_BE);
    assign wr_addr    = {bus_off, ~upper_only};
    assign wr_nib     = upper_only ? bus_wdata[ODD_LO_LSB +: NIB_W]
                                   : bus_wdata[EVEN_LO_LSB +: NIB_W];
    assign prn_load   = accept && bus_we && upper_only && (bus_off == PRN_OFF);
    assign tmr_start  = (accept && (bus_we || !use_shadow_q)) || (state_q == ST_GAP);

    nbb_strobe_timer #(.STROBE_CYC(STROBE_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (tmr_start),
        .active (tmr_active),
        .done   (tmr_done)
    );

    nbb_shadow_file u_shadow (
        .clk      (clk),
        .rst      (rst),
        .wen      (accept && bus_we),
        .waddr    (wr_addr),
        .wnib     (wr_nib),
        .rpair    (bus_off),
        .even_nib (sh_even),
        .odd_nib  (sh_odd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            op_q         <= '0;
            odd_phase_q  <= 1'b0;
            even_q       <= '0;
            use_shadow_q <= 1'b0;
            rdata_q      <= '0;
            ready_q      <= 1'b0;
            addr_q       <= '0;
            wnib_q       <= '0;
            prn_q        <= '0;
        end else begin
            ready_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q <= '{we: bus_we, off: bus_off};
                        if (bus_we) begin
                            addr_q       <= wr_addr;
                            wnib_q       <= wr_nib;
                            use_shadow_q <= (bus_off < SPLIT_OFF) ||
                                            ((bus_off == SPLIT_OFF) && upper_only);
                            if (prn_load) prn_q <= bus_wdata[15:8];
                            state_q <= ST_STROBE;
                        end else if (use_shadow_q) begin
                            rdata_q <= merge_ports(place_pair(sh_even, sh_odd),
                                                   bus_off, sw_cfg, prn_status);
                            ready_q <= 1'b1;
                        end else begin
                            addr_q      <= {bus_off, 1'b0};
                            odd_phase_q <= 1'b0;
                            state_q     <= ST_STROBE;
                        end
                    end
                end
                ST_STROBE: begin
                    if (tmr_done) begin
                        if (op_q.we) begin
                            ready_q <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (!odd_phase_q) begin
                            even_q      <= clk_rdata;
                            addr_q      <= {op_q.off, 1'b1};
                            odd_phase_q <= 1'b1;
                            state_q     <= ST_GAP;
                        end else begin
                            rdata_q <= merge_ports(place_pair(even_q, clk_rdata),
                                                   op_q.off, sw_cfg, prn_status);
                            ready_q <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_GAP:  state_q <= ST_STROBE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_ready = ready_q;
    assign clk_addr  = addr_q;
    assign clk_wdata = wnib_q;
    assign clk_rd    = tmr_active && !op_q.we;
    assign clk_wr    = tmr_active && op_q.we;
    assign prn_data  = prn_q;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(clk_rd && clk_wr)); // R9
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_ready |-> (!clk_rd && !clk_wr)); // R9
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (clk_rd && $past(clk_rd)) |-> $stable(clk_addr)); // R2
    AST_PRN_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(prn_data) |-> $past(prn_load)); // R7
    AST_SHADOW_FAST: assert property (@(posedge clk) disable iff (rst)
        (accept && !bus_we && use_shadow_q) |=> (bus_ready && !clk_rd)); // R8
endmodule

// File: tb/nibble_clock_bridge_bench.sv
module nibble_clock_bridge_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;
    localparam int NV         = 14;

    // {we, off[2:0], be[3:0], wdata[31:0]}
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 3'd0, 4'b1111, 32'h0},          // live read, switch overlay
        {1'b0, 3'd7, 4'b1111, 32'h0},          // live read, status overlay
        {1'b1, 3'd2, 4'b1100, 32'h000000A0},   // reg4 <- A, shadow
        {1'b0, 3'd2, 4'b1111, 32'h0},
        {1'b1, 3'd2, 4'b1111, 32'h00700000},   // reg5 <- 7
        {1'b0, 3'd2, 4'b1111, 32'h0},
        {1'b1, 3'd7, 4'b1100, 32'h0000C3B0},   // reg14 <- B, printer C3, live
        {1'b0, 3'd7, 4'b1111, 32'h0},
        {1'b1, 3'd6, 4'b1100, 32'h00000090},   // reg12 <- 9, shadow
        {1'b0, 3'd6, 4'b1111, 32'h0},
        {1'b1, 3'd6, 4'b0011, 32'h00500000},   // reg13 <- 5, live
        {1'b0, 3'd3, 4'b1111, 32'h0},
        {1'b1, 3'd1, 4'b1111, 32'h00E00000},   // reg3 <- E, shadow
        {1'b0, 3'd0, 4'b1111, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_off = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [3:0]  clk_addr, clk_wdata, clk_rdata;
    logic        clk_rd, clk_wr;
    logic [7:0]  sw_cfg = 8'h5A;
    logic [7:0]  prn_status = 8'h3C;
    logic [7:0]  prn_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_clock_bridge u_nibble_clock_bridge (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_off(bus_off),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .clk_addr(clk_addr), .clk_wdata(clk_wdata), .clk_rdata(clk_rdata),
        .clk_rd(clk_rd), .clk_wr(clk_wr), .sw_cfg(sw_cfg), .prn_status(prn_status),
        .prn_data(prn_data)
    );

    // clock device model
    logic [3:0] chip_mem [16];
    logic       poke_en = 1'b0;
    logic [3:0] poke_addr = '0, poke_val = '0;
    always @(posedge clk) begin
        if (poke_en)     chip_mem[poke_addr] <= poke_val;
        else if (clk_wr) chip_mem[clk_addr] <= clk_wdata;
    end
    assign clk_rdata = clk_rd ? chip_mem[clk_addr] : 4'h0;

    // strobe monitor
    int         rd_cyc, wr_cyc;
    logic [3:0] first_rd_addr, last_rd_addr;
    always @(negedge clk) begin
        if (clk_rd) begin
            if (rd_cyc == 0) first_rd_addr = clk_addr;
            last_rd_addr = clk_addr;
            rd_cyc++;
        end
        if (clk_wr) wr_cyc++;
    end

    // reference model
    logic [3:0] mdl_sh [16];
    logic [3:0] mdl_chip [16];
    logic       mdl_live;
    logic [7:0] mdl_prn;

    int n_checks = 0, n_fails = 0, cyc = 0;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_checks++; n_fails++;
            $display("FAIL R9 watchdog: actual cycles %0d expected below %0d", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] fmt(input logic [3:0] ev, input logic [3:0] od,
                                        input logic [2:0] off);
        logic [31:0] w;
        w = '0;
        w[31:28] = ev; w[23:20] = ev; w[15:12] = od; w[7:4] = od;
        if (off == 3'd0) w[31:24] = sw_cfg;
        if (off == 3'd7) w[23:16] = ~prn_status;
        return w;
    endfunction

    task automatic poke(input logic [3:0] a, input logic [3:0] v);
        @(negedge clk); poke_en = 1'b1; poke_addr = a; poke_val = v;
        @(negedge clk); poke_en = 1'b0;
        mdl_chip[a] = v;
    endtask

    task automatic run_op(input logic we, input logic [2:0] off, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        rd_cyc = 0; wr_cyc = 0;
        bus_req = 1'b1; bus_we = we; bus_off = off; bus_be = be; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        lat = 1;
        while (!bus_ready && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        rd = bus_rdata;
    endtask

    task automatic model_op(input logic we, input logic [2:0] off, input logic [3:0] be,
                            input logic [31:0] wd);
        logic [31:0] rd, exp;
        int lat;
        logic [3:0] idx, nib;
        logic upper;
        upper = (be == 4'b1100);
        run_op(we, off, be, wd, rd, lat);
        if (we) begin
            idx = upper ? {off, 1'b0} : {off, 1'b1};
            nib = upper ? wd[7:4] : wd[23:20];
            mdl_sh[idx] = nib; mdl_chip[idx] = nib;
            if (upper && off == 3'd7) mdl_prn = wd[15:8];
            mdl_live = !((off < 3'd6) || (off == 3'd6 && upper));
            chk("R6 device nibble", {28'h0, chip_mem[idx]}, {28'h0, nib});
            chk("R7 printer data", {24'h0, prn_data}, {24'h0, mdl_prn});
            chk("R9 write latency", lat, 3);
            chk("R9 write strobe width", wr_cyc, 2);
        end else begin
            exp = mdl_live ? fmt(mdl_chip[{off,1'b0}], mdl_chip[{off,1'b1}], off)
                           : fmt(mdl_sh[{off,1'b0}], mdl_sh[{off,1'b1}], off);
            chk("R3/R4/R5/R8 read data", rd, exp);
            chk("R8/R9 read latency", lat, mdl_live ? 6 : 1);
            chk("R9 read strobe cycles", rd_cyc, mdl_live ? 4 : 0);
            if (mdl_live) begin
                chk("R2 first address", {28'h0, first_rd_addr}, {28'h0, off, 1'b0});
                chk("R2 second address", {28'h0, last_rd_addr}, {28'h0, off, 1'b1});
            end
        end
    endtask

    initial begin
        logic [31:0] rd, exp;
        int lat;
        for (int i = 0; i < 16; i++) begin
            chip_mem[i] = 4'((i * 5 + 3) & 15);
            mdl_chip[i] = 4'((i * 5 + 3) & 15);
            mdl_sh[i]   = 4'h0;
        end
        mdl_live = 1'b1;
        mdl_prn  = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 ready after reset", {31'h0, bus_ready}, 32'h0);
        chk("R1 strobes after reset", {30'h0, clk_rd, clk_wr}, 32'h0);
        chk("R1 printer data after reset", {24'h0, prn_data}, 32'h0);

        for (int v = 0; v < NV; v++)
            model_op(VEC[v][39], VEC[v][38:36], VEC[v][35:32], VEC[v][31:0]);

        // R1: shadow holds zeros from reset (reg0/reg1 never written)
        chk("R1 shadow zero", {24'h0, mdl_sh[0], mdl_sh[1]}, 32'h0);

        // switch back to live with a lower-half write at offset 7
        model_op(1'b1, 3'd7, 4'b0011, 32'h00D00000);

        // R10: request raised while a live read is in flight
        @(negedge clk);
        rd_cyc = 0;
        bus_req = 1'b1; bus_we = 1'b0; bus_off = 3'd7; bus_be = 4'b1111;
        @(negedge clk);
        bus_we = 1'b1; bus_be = 4'b1100; bus_wdata = 32'h0000AAF0;
        @(negedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        lat = 3;
        while (!bus_ready && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        exp = fmt(mdl_chip[14], mdl_chip[15], 3'd7);
        chk("R10 read during stray request", bus_rdata, exp);
        chk("R10 printer untouched", {24'h0, prn_data}, {24'h0, mdl_prn});
        chk("R10 device reg untouched", {28'h0, chip_mem[14]}, {28'h0, mdl_chip[14]});
        model_op(1'b0, 3'd7, 4'b1111, 32'h0);   // still live: R10 flag unchanged

        // R8: device changes underneath, live read follows it
        poke(4'd8, 4'h2);
        poke(4'd9, 4'hF);
        model_op(1'b0, 3'd4, 4'b1111, 32'h0);

        // R8: after a shadow-selecting write, device changes are not seen
        model_op(1'b1, 3'd5, 4'b1100, 32'h00000060);
        poke(4'd11, 4'h1);
        model_op(1'b0, 3'd5, 4'b1111, 32'h0);
        model_op(1'b0, 3'd4, 4'b1111, 32'h0);

        summary();
        $finish;
    end
endmodule